// File: doc/BRIEF.md
# Power Event Interrupt Flag Register

This block turns wake and power-transition events into sticky flags that firmware can read, and it raises one interrupt request for the power events. It watches an asynchronous push-button line and an asynchronous power-good line, which comes from PLL lock. Each line passes through its own synchroniser and then an edge detector. A rising button edge latches the button flag. A rising power-good edge latches the power-rise flag, and a falling power-good edge latches the brownout flag.

Firmware clears a flag by writing zero to its bit through a simple write port. A write of one leaves the bit alone. A sleep or display-only mode request also clears the button flag, so a stale press does not survive into the next low-power period. When the part wakes into brownout because of the button or the wake timer, that wake is not a loss of power. A short masking window that starts at every wake event keeps a power-good fall inside the window from setting the brownout flag. The power-rise and brownout flags drive the shared interrupt request. The button flag does not.

Top module: `pwr_evt_flags`

## Requirements
- R1: After reset, `rdData` is 3'b000 and `irq` is 0.
- R2: A low-to-high change on `btnIn`, applied between two clock edges, sets `rdData[0]` on the third rising edge after the change and not earlier.
- R3: A write (`wrEn`=1) clears each flag whose `wrData` bit is 0 and leaves each flag whose `wrData` bit is 1 unchanged. Bit 0 is the button flag, bit 1 is power-rise and bit 2 is brownout.
- R4: A one-cycle `sleepReq` pulse clears `rdData[0]` on the next edge and leaves bits 1 and 2 unchanged.
- R5: A low-to-high change on `pgIn` sets `rdData[1]` on the third rising edge after the change.
- R6: A high-to-low change on `pgIn` sets `rdData[2]` on the third rising edge after the change, unless R7 applies. Once set, the flag stays set until a write clears it.
- R7: A wake event is a synchronised button rising edge or a `wakeTimerEvt` pulse. A detected power-good fall in the same cycle as a wake event does not set `rdData[2]`. Neither does a fall in any of the `MaskCycles` (default 4) cycles after the wake event. Under the defaults, with the timer pulse sampled at edge j, a `pgIn` fall driven d cycles after the timer pulse is suppressed for d ≤ 2 and sets the flag for d ≥ 3.
- R8: When a set event and a clear (a write of 0 or `sleepReq`) reach the same flag in the same cycle, the flag ends up set.
- R9: `irq` equals `rdData[1]` OR `rdData[2]` in every cycle. The button flag has no effect on `irq`.
- R10: A flag changes only through a set event, a write of 0 to its bit, or `sleepReq` for bit 0. Writes of all ones leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| btnIn | input | 1 | Push-button line, asynchronous |
| pgIn | input | 1 | Power-good (PLL lock) line, asynchronous |
| wakeTimerEvt | input | 1 | One-cycle wake-timer event, synchronous |
| sleepReq | input | 1 | One-cycle sleep or display-only mode request, synchronous |
| wrEn | input | 1 | Flag register write strobe |
| wrData | input | 3 | Write data: a 0 clears the matching flag |
| rdData | output | 3 | Flag register read value {brownout, rise, button} |
| irq | output | 1 | Shared power-event interrupt request |

## Verification
Each asynchronous line takes three rising edges to reach its flag: two synchroniser stages and the flag register. The bench drives `btnIn` and `pgIn` at a falling edge and samples at the falling edge after the second rising edge, where the flag must still be clear. It samples again at the falling edge after the third rising edge, where the flag must be set. A write, a sleep request or a timer pulse takes effect on the first rising edge after it is driven, so the bench samples those results one falling edge later. In the collision tests the bench lines the clear up with the third edge of a set, and it sweeps the power-good fall across several offsets from a timer pulse, from d = 0 to d = 4, so that the masking window is probed on both sides of its edge.

// File: rtl/pef_pkg.sv
package pef_pkg;
  localparam int FlagCount = 3;
  localparam int BitBtn    = 0;
  localparam int BitRise   = 1;
  localparam int BitBrown  = 2;

  // Per-flag set and clear strobes from control to the flag datapath
  typedef struct packed {
    logic [FlagCount-1:0] setVec;
    logic [FlagCount-1:0] clrVec;
  } flagStrobes_t;
endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
  parameter int Width  = 2,
  parameter int Stages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] asyncIn,
  output logic [Width-1:0] syncOut
);
  localparam int PipeW = Width * Stages;

  logic [PipeW-1:0] pipe;

  generate
    if (Stages < 2) begin : g_bad
      initial $error("pef_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[PipeW-Width-1:0], asyncIn};
  end

  assign syncOut = pipe[PipeW-1 -: Width];
endmodule

// File: rtl/pef_ctrl.sv
module pef_ctrl
  import pef_pkg::*;
#(
  parameter int SyncStages = 2,
  parameter int MaskCycles = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 btnIn,
  input  logic                 pgIn,
  input  logic                 wakeTimerEvt,
  input  logic                 sleepReq,
  input  logic                 wrEn,
  input  logic [FlagCount-1:0] wrData,
  output flagStrobes_t         stb
);
  localparam int MaskW = $clog2(MaskCycles + 2);
  localparam logic [MaskW-1:0] MaskLoad = MaskW'(MaskCycles);

  logic [1:0] syncd;
  logic [1:0] prevSync;
  logic       btnRise;
  logic       pgRise;
  logic       pgFall;
  logic       wakeEvt;
  logic       maskActive;
  logic [MaskW-1:0] maskCnt;

  pef_sync #(.Width(2), .Stages(SyncStages)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({pgIn, btnIn}),
    .syncOut (syncd)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSync <= '0;
    else       prevSync <= syncd;
  end

  assign btnRise = syncd[0] & ~prevSync[0];
  assign pgRise  = syncd[1] & ~prevSync[1];
  assign pgFall  = ~syncd[1] & prevSync[1];
  assign wakeEvt = btnRise | wakeTimerEvt;

  // Window after a wake event in which a power-good fall is not a brownout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                maskCnt <= '0;
    else if (wakeEvt)         maskCnt <= MaskLoad;
    else if (maskCnt != '0)   maskCnt <= maskCnt - 1'b1;
  end

  assign maskActive = wakeEvt | (maskCnt != '0);

  always_comb begin
    stb = '0;
    stb.setVec[BitBtn]   = btnRise;
    stb.setVec[BitRise]  = pgRise;
    stb.setVec[BitBrown] = pgFall & ~maskActive;
    stb.clrVec           = wrEn ? ~wrData : '0;
    stb.clrVec[BitBtn]   = stb.clrVec[BitBtn] | sleepReq;
  end
endmodule

// File: rtl/pef_flags.sv
module pef_flags
  import pef_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flagStrobes_t         stb,
  output logic [FlagCount-1:0] flags,
  output logic                 irq
);
  generate
    for (genvar i = 0; i < FlagCount; i++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              flags[i] <= 1'b0;
        else if (stb.setVec[i]) flags[i] <= 1'b1;
        else if (stb.clrVec[i]) flags[i] <= 1'b0;
      end
    end
  endgenerate

  assign irq = flags[BitRise] | flags[BitBrown];
endmodule

// File: rtl/pwr_evt_flags.sv
module pwr_evt_flags
  import pef_pkg::*;
#(
  parameter int SyncStages = 2,
  parameter int MaskCycles = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnIn,
  input  logic       pgIn,
  input  logic       wakeTimerEvt,
  input  logic       sleepReq,
  input  logic       wrEn,
  input  logic [2:0] wrData,
  output logic [2:0] rdData,
  output logic       irq
);
  flagStrobes_t stb;

  pef_ctrl #(.SyncStages(SyncStages), .MaskCycles(MaskCycles)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .btnIn        (btnIn),
    .pgIn         (pgIn),
    .wakeTimerEvt (wakeTimerEvt),
    .sleepReq     (sleepReq),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .stb          (stb)
  );

  pef_flags u_flags (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .flags (rdData),
    .irq   (irq)
  );
endmodule

// File: rtl/pwr_evt_flags_chk.sv
module pwr_evt_flags_chk
  import pef_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         wakeTimerEvt,
  input logic         sleepReq,
  input logic         wrEn,
  input logic [2:0]   wrData,
  input logic [2:0]   rdData,
  input logic         irq,
  input flagStrobes_t stb
);
  p_write_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[0] && !stb.setVec[0]) |=> !rdData[0]);

  p_sleep_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !stb.setVec[0]) |=> !rdData[0]);

  p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.setVec[1] |=> rdData[1]);

  p_brown_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2] && !(wrEn && !wrData[2])) |=> rdData[2]);

  p_timer_masks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wakeTimerEvt && !rdData[2]) |=> !rdData[2]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.setVec[0] |=> rdData[0]);

  p_irq_power_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq == (rdData[1] | rdData[2]));

  p_write_masks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !sleepReq && stb.setVec == '0) |=> rdData == ($past(rdData) & $past(wrData)));
endmodule

bind pwr_evt_flags pwr_evt_flags_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wakeTimerEvt (wakeTimerEvt),
  .sleepReq     (sleepReq),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .rdData       (rdData),
  .irq          (irq),
  .stb          (stb)
);

// File: tb/sim_pwr_evt_flags.sv
`timescale 1ns/1ps
module sim_pwr_evt_flags;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       btnIn = 1'b0;
  logic       pgIn = 1'b0;
  logic       wakeTimerEvt = 1'b0;
  logic       sleepReq = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrData = 3'b000;
  logic [2:0] rdData;
  logic       irq;

  int checks = 0;
  int errs = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_evt_flags u0 (
    .clk(clk), .rstN(rstN), .btnIn(btnIn), .pgIn(pgIn),
    .wakeTimerEvt(wakeTimerEvt), .sleepReq(sleepReq),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Compares {irq, rdData} with the flags expected; irq follows R9
  task automatic expect_flags(input string tag, input logic [2:0] exp);
    logic [3:0] want;
    want = {exp[1] | exp[2], exp};
    checks++;
    if ({irq, rdData} !== want) begin
      errs++;
      $display("FAIL %s: {irq,rdData} actual=%b expected=%b", tag, {irq, rdData}, want);
    end
  endtask

  task automatic write_reg(input logic [2:0] d);
    wrEn = 1'b1; wrData = d;
    step();
    wrEn = 1'b0; wrData = 3'b000;
  endtask

  task automatic pulse_sleep();
    sleepReq = 1'b1;
    step();
    sleepReq = 1'b0;
  endtask

  // Sets all three flags; starts and ends with btnIn and pgIn low
  task automatic set_all();
    btnIn = 1'b1; pgIn = 1'b1;
    step(8);
    pgIn = 1'b0;
    step(3);
    btnIn = 1'b0;
    step(3);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    expect_flags("R1 reset state", 3'b000);

    // R2: button latency
    btnIn = 1'b1;
    step(2);
    expect_flags("R2 button not before third edge", 3'b000);
    step();
    expect_flags("R2 button set", 3'b001);
    btnIn = 1'b0;
    step(8);

    // R3: one leaves, zero clears
    write_reg(3'b111);
    expect_flags("R3 write one keeps button", 3'b001);
    write_reg(3'b110);
    expect_flags("R3 write zero clears button", 3'b000);

    // R4: sleep clears button
    btnIn = 1'b1;
    step(3);
    expect_flags("R4 button set before sleep", 3'b001);
    pulse_sleep();
    expect_flags("R4 sleep clears button", 3'b000);
    btnIn = 1'b0;
    step(8);

    // R5 and R9: power rise
    pgIn = 1'b1;
    step(2);
    expect_flags("R5 rise not before third edge", 3'b000);
    step();
    expect_flags("R5 R9 rise set with irq", 3'b010);
    write_reg(3'b101);
    expect_flags("R5 rise cleared irq low", 3'b000);

    // R6: brownout
    pgIn = 1'b0;
    step(2);
    expect_flags("R6 brownout not before third edge", 3'b000);
    step();
    expect_flags("R6 brownout set", 3'b100);
    step(4);
    expect_flags("R6 brownout sticky", 3'b100);
    write_reg(3'b011);
    expect_flags("R6 brownout cleared", 3'b000);

    // R8: set beats write clear
    btnIn = 1'b1;
    step(2);
    wrEn = 1'b1; wrData = 3'b000;
    step();
    wrEn = 1'b0;
    expect_flags("R8 button set beats write", 3'b001);
    btnIn = 1'b0;
    step(8);
    write_reg(3'b000);
    // R8: set beats sleep clear
    btnIn = 1'b1;
    step(2);
    sleepReq = 1'b1;
    step();
    sleepReq = 1'b0;
    expect_flags("R8 button set beats sleep", 3'b001);
    btnIn = 1'b0;
    step(8);
    write_reg(3'b000);
    // R8: power rise beats write clear
    pgIn = 1'b1;
    step(2);
    wrEn = 1'b1; wrData = 3'b000;
    step();
    wrEn = 1'b0;
    expect_flags("R8 rise set beats write", 3'b010);
    write_reg(3'b000);
    step(4);

    // R7: timer-masked brownout window sweep, pgIn high here
    for (int d = 0; d <= 4; d++) begin
      wakeTimerEvt = 1'b1;
      if (d == 0) pgIn = 1'b0;
      step();
      wakeTimerEvt = 1'b0;
      if (d > 0) begin
        step(d - 1);
        pgIn = 1'b0;
      end
      step(6);
      expect_flags($sformatf("R7 timer offset d=%0d", d), (d >= 3) ? 3'b100 : 3'b000);
      write_reg(3'b000);
      pgIn = 1'b1;
      step(4);
      write_reg(3'b000);
    end

    // R7: button wake in the same cycle as the fall
    btnIn = 1'b1; pgIn = 1'b0;
    step(6);
    expect_flags("R7 button wake masks brownout", 3'b001);
    btnIn = 1'b0;
    write_reg(3'b000);
    step(8);

    // R3 and R10: sweep every write pattern over all-set flags
    for (int d = 0; d < 8; d++) begin
      set_all();
      expect_flags($sformatf("R10 all set before write %0d", d), 3'b111);
      write_reg(3'(d));
      expect_flags($sformatf("R3 R10 write pattern %0d", d), 3'(d) & 3'b111);
      write_reg(3'b000);
    end

    // R4 and R10: sleep leaves power flags
    set_all();
    pulse_sleep();
    expect_flags("R4 R10 sleep keeps power flags", 3'b110);
    write_reg(3'b000);
    expect_flags("R3 final clear", 3'b000);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule